// File: doc/BRIEF.md
# Freeze Handshake and Privilege Guard

This block parks a communication peripheral in a halted configuration state called freeze, and lets it out again. Software raises a freeze request. The controller waits until no frame is being sent or received and the peripheral is out of low-power mode. It then stops the bit-rate prescaler and raises a read-only acknowledge flag. When the request is withdrawn, the prescaler restarts first and the flag drops one cycle later. Software polls the flag to learn when freeze has actually taken effect.

The same block holds a privilege bit that guards a set of marked registers. While the bit is 1, an access to a marked register without supervisor rights is treated like an access to an unimplemented location: it reads as zero, has no write effect and returns a one-cycle bus error. The privilege bit itself is one of those marked registers. Writes to it take effect only while the acknowledge flag is set. All pins are plain control and status levels, with no valid/ready streaming. A bus access is a single-cycle strobe, and its response comes one cycle later.

Top module: `frz_ctl_top`

## Requirements
- R1: After reset the acknowledge flag is 0, the prescaler enable is 1, the bus error is 0, and the privilege bit reads as 1 at bit position PRIV_BIT of the read data.
- R2: With the request high and no activity or low power present at a clock edge, the acknowledge flag reads 1 and the prescaler enable reads 0 after that edge.
- R3: While transmit busy or receive busy is high, the acknowledge flag stays 0 even if the request is high.
- R4: While low power is active, a pending request is not granted; the grant follows the first edge with low power negated and no activity.
- R5: On release, the prescaler enable returns to 1 after the first edge that sees the request low, and the acknowledge flag falls after the next edge.
- R6: A marked access without supervisor rights while the privilege bit is 1 gives a bus error for exactly one cycle after the access, with read data 0.
- R7: A blocked write to the privilege bit leaves it unchanged.
- R8: A write to the privilege bit while the acknowledge flag is 0 is discarded, even from a supervisor.
- R9: While frozen, a permitted write sets the privilege bit. With the bit at 0, non-supervisor accesses to marked registers get no error.
- R10: Supervisor accesses and accesses to unmarked locations never produce a bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_req | input | 1 | Freeze request from the control register |
| tx_busy | input | 1 | Frame transmission in progress |
| rx_busy | input | 1 | Frame reception in progress |
| lp_active | input | 1 | Peripheral is in a low-power mode |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | Access carries supervisor rights |
| acc_marked | input | 1 | Address hits a privilege-guarded register |
| acc_priv_sel | input | 1 | Address hits the privilege-bit register |
| acc_wbit | input | 1 | Write value for the privilege bit |
| frz_ack | output | 1 | Freeze acknowledge, read-only |
| psc_en | output | 1 | Prescaler run enable |
| acc_err | output | 1 | Bus error response, one cycle after a blocked access |
| acc_rdata | output | DATA_W | Read data, one cycle after a read |

## Verification
The bench builds the block with DATA_W = 8 and PRIV_BIT = 3. The privilege bit therefore sits at an interior, non-zero position of a narrow word. A read that returns 8 rather than 1 or 0 shows that the bit is placed and masked correctly. The narrow word also keeps every blocked read's zero easy to compare. These values bring within reach the freeze hold-off by each of transmit, receive and low power, and the two-step release order. They also cover the privilege lock both before and during freeze.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [1:0] {
    FZ_RUN  = 2'd0,
    FZ_HALT = 2'd1,
    FZ_THAW = 2'd2
  } fz_state_e;
endpackage

// File: rtl/frz_fsm.sv
module frz_fsm
  import frz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frz_req,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic lp_active,
  output logic frz_ack,
  output logic psc_en
);
  fz_state_e state_q, state_d;
  logic quiet;

  assign quiet = !tx_busy && !rx_busy && !lp_active;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FZ_RUN:  if (frz_req && quiet) state_d = FZ_HALT;
      FZ_HALT: if (!frz_req) state_d = FZ_THAW;
      FZ_THAW: state_d = FZ_RUN;
      default: state_d = FZ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FZ_RUN;
    else        state_q <= state_d;
  end

  assign frz_ack = (state_q != FZ_RUN);
  assign psc_en  = (state_q != FZ_HALT);

  // R3: activity holds off the grant
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_ack && (tx_busy || rx_busy)) |=> !frz_ack);
  // R4: low power holds off the grant
  assert_lp_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_ack && lp_active) |=> !frz_ack);
  // R2: granted request stops the prescaler
  assert_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_ack && frz_req && quiet) |=> (frz_ack && !psc_en));
  // R5: release restarts the prescaler before the flag drops
  assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack && !psc_en && !frz_req) |=> (frz_ack && psc_en));
  assert_release_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack && psc_en) |=> !frz_ack);
endmodule

// File: rtl/priv_guard.sv
module priv_guard #(
  parameter int DATA_W   = 32,
  parameter int PRIV_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_ack,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_super,
  input  logic              acc_marked,
  input  logic              acc_priv_sel,
  input  logic              acc_wbit,
  output logic              acc_err,
  output logic [DATA_W-1:0] acc_rdata
);
  localparam logic [DATA_W-1:0] PRIV_MASK = DATA_W'(1) << PRIV_BIT;

  logic priv_q;
  logic blocked, wr_ok, rd_hit;

  assign blocked = acc_valid && acc_marked && priv_q && !acc_super;
  assign wr_ok   = acc_valid && acc_write && acc_priv_sel && !blocked && frz_ack;
  assign rd_hit  = acc_valid && !acc_write && acc_priv_sel && !blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q    <= 1'b1;
      acc_err   <= 1'b0;
      acc_rdata <= '0;
    end else begin
      if (wr_ok) priv_q <= acc_wbit;
      acc_err   <= blocked;
      acc_rdata <= rd_hit ? (priv_q ? PRIV_MASK : '0) : '0;
    end
  end

  // R6: blocked access returns an error
  assert_block_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_marked && priv_q && !acc_super) |=> acc_err);
  // R6: errored access reads zero
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == '0));
  // R8: privilege bit frozen unless acknowledged
  assert_priv_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_ack |=> $stable(priv_q));
  // R10: supervisor or unmarked access never errors
  assert_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_super || !acc_marked)) |=> !acc_err);
endmodule

// File: rtl/frz_ctl_top.sv
module frz_ctl_top #(
  parameter int DATA_W   = 32,
  parameter int PRIV_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_req,
  input  logic              tx_busy,
  input  logic              rx_busy,
  input  logic              lp_active,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_super,
  input  logic              acc_marked,
  input  logic              acc_priv_sel,
  input  logic              acc_wbit,
  output logic              frz_ack,
  output logic              psc_en,
  output logic              acc_err,
  output logic [DATA_W-1:0] acc_rdata
);
  logic ack_w;

  frz_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frz_req   (frz_req),
    .tx_busy   (tx_busy),
    .rx_busy   (rx_busy),
    .lp_active (lp_active),
    .frz_ack   (ack_w),
    .psc_en    (psc_en)
  );

  priv_guard #(.DATA_W(DATA_W), .PRIV_BIT(PRIV_BIT)) u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .frz_ack      (ack_w),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_super    (acc_super),
    .acc_marked   (acc_marked),
    .acc_priv_sel (acc_priv_sel),
    .acc_wbit     (acc_wbit),
    .acc_err      (acc_err),
    .acc_rdata    (acc_rdata)
  );

  assign frz_ack = ack_w;
endmodule

// File: tb/frz_ctl_top_tb.sv
module frz_ctl_top_tb;
  localparam int DW = 8;
  localparam int PB = 3;

  typedef struct packed {
    logic          ack;
    logic          psc;
    logic          err;
    logic [DW-1:0] rd;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_req = 0, tx_busy = 0, rx_busy = 0, lp_active = 0;
  logic acc_valid = 0, acc_write = 0, acc_super = 0, acc_marked = 0;
  logic acc_priv_sel = 0, acc_wbit = 0;
  logic frz_ack, psc_en, acc_err;
  logic [DW-1:0] acc_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  exp_t  q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  frz_ctl_top #(.DATA_W(DW), .PRIV_BIT(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .lp_active(lp_active), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_super(acc_super), .acc_marked(acc_marked),
    .acc_priv_sel(acc_priv_sel), .acc_wbit(acc_wbit), .frz_ack(frz_ack),
    .psc_en(psc_en), .acc_err(acc_err), .acc_rdata(acc_rdata)
  );

  // drive one cycle, then queue the outputs expected after that edge
  task automatic step(input string tag, input logic req, input logic txb,
                      input logic rxb, input logic lp, input logic av,
                      input logic aw, input logic sup, input logic mk,
                      input logic sel, input logic wb, input exp_t e);
    frz_req = req; tx_busy = txb; rx_busy = rxb; lp_active = lp;
    acc_valid = av; acc_write = aw; acc_super = sup; acc_marked = mk;
    acc_priv_sel = sel; acc_wbit = wb;
    @(posedge clk);
    #1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  function automatic exp_t mk_e(logic a, logic p, logic e, logic [DW-1:0] r);
    exp_t x;
    x.ack = a; x.psc = p; x.err = e; x.rd = r;
    return x;
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        exp_t  e;
        exp_t  got;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        got = mk_e(frz_ack, psc_en, acc_err, acc_rdata);
        n_chk++;
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s: actual ack=%b psc=%b err=%b rd=%h expected ack=%b psc=%b err=%b rd=%h",
                   t, got.ack, got.psc, got.err, got.rd, e.ack, e.psc, e.err, e.rd);
        end
      end
    end
  end

  initial begin
    localparam logic [DW-1:0] P1 = DW'(1) << PB;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state and privilege readback
    step("R1 idle",      0,0,0,0, 0,0,0,0,0,0, mk_e(0,1,0,0));
    step("R1 priv read", 0,0,0,0, 1,0,1,1,1,0, mk_e(0,1,0,P1));
    // R6 user read blocked, error is a single pulse
    step("R6 user read", 0,0,0,0, 1,0,0,1,1,0, mk_e(0,1,1,0));
    step("R6 pulse end", 0,0,0,0, 0,0,0,0,0,0, mk_e(0,1,0,0));
    // R7 blocked write leaves bit
    step("R7 user write",0,0,0,0, 1,1,0,1,1,0, mk_e(0,1,1,0));
    step("R7 readback",  0,0,0,0, 1,0,1,1,1,0, mk_e(0,1,0,P1));
    // R8 supervisor write discarded while not frozen
    step("R8 sup write", 0,0,0,0, 1,1,1,1,1,0, mk_e(0,1,0,0));
    step("R8 readback",  0,0,0,0, 1,0,1,1,1,0, mk_e(0,1,0,P1));
    // R10 unmarked user access, no error
    step("R10 unmarked", 0,0,0,0, 1,0,0,0,0,0, mk_e(0,1,0,0));
    // R3 activity holds off grant
    step("R3 tx busy",   1,1,0,0, 0,0,0,0,0,0, mk_e(0,1,0,0));
    step("R3 rx busy",   1,0,1,0, 0,0,0,0,0,0, mk_e(0,1,0,0));
    // R4 low power holds off grant
    step("R4 low power", 1,0,0,1, 0,0,0,0,0,0, mk_e(0,1,0,0));
    step("R4 lp exit",   1,0,0,0, 0,0,0,0,0,0, mk_e(1,0,0,0));
    // R2 frozen state persists under activity
    step("R2 frozen",    1,1,1,0, 0,0,0,0,0,0, mk_e(1,0,0,0));
    // R9 supervisor clears privilege while frozen
    step("R9 sup write", 1,0,0,0, 1,1,1,1,1,0, mk_e(1,0,0,0));
    step("R9 readback",  1,0,0,0, 1,0,1,1,1,0, mk_e(1,0,0,0));
    step("R9 user open", 1,0,0,0, 1,0,0,1,1,0, mk_e(1,0,0,0));
    step("R9 user set",  1,0,0,0, 1,1,0,1,1,1, mk_e(1,0,0,0));
    step("R9 readback2", 1,0,0,0, 1,0,1,1,1,0, mk_e(1,0,0,P1));
    // R5 release order
    step("R5 psc first", 0,0,0,0, 0,0,0,0,0,0, mk_e(1,1,0,0));
    step("R5 ack falls", 0,0,0,0, 0,0,0,0,0,0, mk_e(0,1,0,0));
    // R2 fresh grant from idle
    step("R2 grant",     1,0,0,0, 0,0,0,0,0,0, mk_e(1,0,0,0));
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule